// File: doc/BRIEF.md
# Debounced Input Port with Interrupts

A four-pin input port for a small microcontroller. Every pin goes through a two-flop synchroniser and then a debouncer. A new level is accepted only after it has held for a set number of sample ticks. The debounced levels are what the CPU reads. A rising edge of a debounced level raises a per-pin interrupt request, but only when that pin is enabled in a read/write enable register. The enable register resets to all-disabled.

The CPU uses a plain register port: a 2-bit address, a read strobe, a write strobe, write data and combinational read data. Reading the request register returns its bits and clears all of them at that clock edge. The same read issues a one-cycle clear pulse, which the global interrupt controller uses to drop the port's summary flag. A one-cycle set pulse tells that controller that a new request was latched. When both pulses occur in the same cycle, the controller should give the set pulse priority. The debounced level of pin 3 is also driven out to feed an external event counter.

Register addresses are 0 for pin levels (read-only), 1 for pending requests (read-only, cleared on read), 2 for the enable mask (read/write) and 3 unused (reads 0). In every register, bit n belongs to pin n.

Top module: `dbin_port`

## Requirements
- R1: A change on a pin reaches the level register only after the synchronised value has differed from the accepted level on STABLE_TICKS consecutive sample ticks, one tick every TICK_DIV cycles. A shorter glitch is never accepted.
- R2: A read at address 0 returns the debounced levels, with bit n holding pin n.
- R3: The enable mask at address 2 is read/write and resets to 0.
- R4: The pending register at address 1 resets to 0.
- R5: A read at address 1 returns the pending bits and clears all of them at that clock edge.
- R6: A read at address 1 raises `irq_clr` for exactly that cycle.
- R7: `count_src` equals the debounced level of pin 3.
- R8: A rising debounced edge on pin n with enable bit n = 1 sets pending bit n and raises `irq_set` in that cycle. A falling edge sets nothing.
- R9: A rising edge on a disabled pin sets nothing, and enabling that pin afterwards creates no request.
- R10: A rising edge in the same cycle as a clearing read leaves its pending bit set after the read.
- R11: Disabling a pin does not clear its pending bit, and re-writing an enable bit of 1 while the bit is pending does not add a request.
- R12: Writes to address 0 or address 1 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | NPINS | Raw asynchronous pin levels |
| addr | input | 2 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | NPINS | Write data |
| rdata | output | NPINS | Read data for the current address (combinational) |
| irq_set | output | 1 | One-cycle pulse when a new request is latched |
| irq_clr | output | 1 | One-cycle pulse on a read of the pending register |
| count_src | output | 1 | Debounced pin 3 level for the event counter |

## Verification
The assertions assume that read and write strobes are never asserted together, and that `addr` stays stable while a strobe is high. The bench changes `addr` and the strobes only at falling clock edges and issues one access at a time. Pins are changed with no relation to the clock, and each change is held for well beyond the debounce window, except where a glitch is injected on purpose. In the test of R10, the read is placed in the cycle of an observed `irq_set` pulse.

// File: rtl/dbin_port_pkg.sv
package dbin_port_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_LEVEL = 2'd0,
    REG_PEND  = 2'd1,
    REG_MASK  = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dbin_sync.sv
// Multi-stage synchroniser for one asynchronous bit.
module dbin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg_q <= '0;
        else        stg_q <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], din};
    end
  endgenerate

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/dbin_tick.sv
// Sample tick generator shared by all debouncers.
module dbin_tick #(
  parameter int TICK_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(TICK_DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                         cnt_q <= '0;
        else if (cnt_q == CW'(TICK_DIV-1))  cnt_q <= '0;
        else                                cnt_q <= cnt_q + 1'b1;
      assign tick = (cnt_q == CW'(TICK_DIV-1));
    end
  endgenerate
endmodule

// File: rtl/dbin_debounce.sv
// Accepts a new level after STABLE_TICKS consecutive differing ticks.
module dbin_debounce #(
  parameter int STABLE_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(STABLE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_TICKS - 1);

  logic          level_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      run_q   <= '0;
    end else if (tick) begin
      if (din == level_q) begin
        run_q <= '0;
      end else if (run_q == LAST) begin
        level_q <= din;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign dout = level_q;
endmodule

// File: rtl/dbin_irq_regs.sv
// Edge detection, enable mask and clear-on-read pending register.
module dbin_irq_regs
  import dbin_port_pkg::*;
#(
  parameter int NPINS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  level,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  pend,
  output logic [NPINS-1:0]  mask,
  output logic              set_pulse,
  output logic              clr_pulse
);
  logic [NPINS-1:0] prev_q, pend_q, mask_q, rise, new_req;
  logic             rd_pend, wr_mask;

  assign rd_pend = rd_en && (addr == REG_PEND);
  assign wr_mask = wr_en && (addr == REG_MASK);
  assign rise    = level & ~prev_q;
  assign new_req = rise & mask_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= wdata;

  // New requests win over the clearing read in the same cycle.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (rd_pend ? '0 : pend_q) | new_req;

  assign pend      = pend_q;
  assign mask      = mask_q;
  assign set_pulse = |new_req;
  assign clr_pulse = rd_pend;
endmodule

// File: rtl/dbin_port.sv
module dbin_port
  import dbin_port_pkg::*;
#(
  parameter int NPINS        = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int STABLE_TICKS = 4,
  parameter int TICK_DIV     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_in,
  input  logic [1:0]       addr,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] rdata,
  output logic             irq_set,
  output logic             irq_clr,
  output logic             count_src
);
  logic             tick;
  logic [NPINS-1:0] synced, level, pend_w, mask_w;

  dbin_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      dbin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pins_in[i]), .dout(synced[i])
      );
      dbin_debounce #(.STABLE_TICKS(STABLE_TICKS)) u_deb (
        .clk(clk), .rst_n(rst_n), .tick(tick), .din(synced[i]), .dout(level[i])
      );
    end
  endgenerate

  dbin_irq_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .level(level), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
    .pend(pend_w), .mask(mask_w),
    .set_pulse(irq_set), .clr_pulse(irq_clr)
  );

  always_comb begin
    case (addr)
      REG_LEVEL: rdata = level;
      REG_PEND:  rdata = pend_w;
      REG_MASK:  rdata = mask_w;
      default:   rdata = '0;
    endcase
  end

  assign count_src = level[NPINS-1];
endmodule

// File: rtl/dbin_port_chk.sv
module dbin_port_chk
  import dbin_port_pkg::*;
#(
  parameter int NPINS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       addr,
  input logic             rd_en,
  input logic [NPINS-1:0] pend,
  input logic [NPINS-1:0] mask,
  input logic             irq_set,
  input logic             irq_clr
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (pend == '0 && mask == '0)); // R3

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == REG_PEND && !irq_set) |=> pend == '0); // R5

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !irq_set) |=> pend == '0); // R6

  AST_SET_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend & ~$past(pend) & ~$past(mask)) == '0); // R9

  AST_SET_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> pend != '0); // R10

  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_clr |=> (pend & $past(pend)) == $past(pend)); // R11
endmodule

bind dbin_port dbin_port_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
  .pend(pend_w), .mask(mask_w), .irq_set(irq_set), .irq_clr(irq_clr)
);

// File: tb/dbin_port_bench.sv
module dbin_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pins_in = '0;
  logic [1:0] addr = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  logic       irq_set, irq_clr, count_src;

  int checks = 0, fails = 0, set_cnt = 0;

  always #2 clk = ~clk;

  dbin_port #(.NPINS(4), .SYNC_STAGES(2), .STABLE_TICKS(4), .TICK_DIV(2)) u_dbin_port (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq_set(irq_set),
    .irq_clr(irq_clr), .count_src(count_src)
  );

  always @(negedge clk) if (rst_n && irq_set) set_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [3:0] d, output logic c);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata; c = irq_clr;
    @(negedge clk);
    rd_en = 1'b0;
    #1 chk("R6 pulse ends", irq_clr, 1'b0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [3:0] d; logic c;
    rd(2'd1, d, c); chk("R4 pending reset", d, 4'h0);
    rd(2'd2, d, c); chk("R3 mask reset", d, 4'h0);
  endtask

  task automatic t_debounce();
    logic [3:0] d; logic c;
    pins_in = 4'h1; repeat (3) @(negedge clk); pins_in = 4'h0;
    repeat (20) @(negedge clk);
    rd(2'd0, d, c); chk("R1 glitch rejected", d, 4'h0);
    pins_in = 4'h2; repeat (3) @(negedge clk);
    rd(2'd0, d, c); chk("R1 not yet accepted", d, 4'h0);
    settle();
    rd(2'd0, d, c); chk("R1 accepted", d, 4'h2);
    pins_in = 4'h0; settle();
  endtask

  task automatic t_level();
    logic [3:0] d; logic c;
    pins_in = 4'hA; settle();
    rd(2'd0, d, c); chk("R2 level A", d, 4'hA);
    chk("R7 count_src high", count_src, 1'b1);
    pins_in = 4'h5; settle();
    rd(2'd0, d, c); chk("R2 level 5", d, 4'h5);
    chk("R7 count_src low", count_src, 1'b0);
    pins_in = 4'h0; settle();
    rd(2'd1, d, c);
  endtask

  task automatic t_mask_rw();
    logic [3:0] d; logic c;
    wr(2'd2, 4'h6); rd(2'd2, d, c); chk("R3 mask write", d, 4'h6);
    wr(2'd0, 4'hF); wr(2'd1, 4'hF);
    rd(2'd2, d, c); chk("R12 mask untouched", d, 4'h6);
    rd(2'd1, d, c); chk("R12 pending untouched", d, 4'h0);
    wr(2'd2, 4'h0);
  endtask

  task automatic t_edge();
    logic [3:0] d; logic c;
    wr(2'd2, 4'h5); set_cnt = 0;
    pins_in = 4'h7; settle();
    chk("R8 one set pulse", set_cnt, 1);
    rd(2'd1, d, c); chk("R8 pending", d, 4'h5);
    chk("R6 clear pulse", c, 1'b1);
    rd(2'd1, d, c); chk("R5 cleared", d, 4'h0);
    set_cnt = 0; pins_in = 4'h0; settle();
    chk("R8 fall no pulse", set_cnt, 0);
    rd(2'd1, d, c); chk("R8 fall no request", d, 4'h0);
    wr(2'd2, 4'h0);
  endtask

  task automatic t_masked();
    logic [3:0] d; logic c;
    pins_in = 4'h8; settle();
    rd(2'd1, d, c); chk("R9 masked edge", d, 4'h0);
    wr(2'd2, 4'h8);
    rd(2'd1, d, c); chk("R9 late enable", d, 4'h0);
    pins_in = 4'h0; settle(); pins_in = 4'h8; settle();
    wr(2'd2, 4'h8);
    wr(2'd2, 4'h0);
    rd(2'd1, d, c); chk("R11 kept after disable", d, 4'h8);
    rd(2'd1, d, c); chk("R11 no extra request", d, 4'h0);
    pins_in = 4'h0; settle();
  endtask

  task automatic t_race();
    logic [3:0] d; logic c; bit hit = 0;
    wr(2'd2, 4'h1);
    rd(2'd1, d, c);
    pins_in = 4'h1;
    for (int k = 0; k < 60 && !hit; k++) begin
      @(negedge clk);
      if (irq_set) begin
        addr = 2'd1; rd_en = 1'b1; hit = 1;
        @(negedge clk); rd_en = 1'b0;
      end
    end
    chk("R10 race reached", hit, 1);
    rd(2'd1, d, c); chk("R10 edge survives read", d, 4'h1);
    wr(2'd2, 4'h0); pins_in = 4'h0; settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_debounce();
    t_level();
    t_mask_rw();
    t_edge();
    t_masked();
    t_race();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule